// File: doc/BRIEF.md
# Compand-Bit Page Power Meter

This block estimates the power of a signal from the output of a one-bit delta-modulation encoder. The encoder bits arrive one at a time with a qualifying strobe. Every accepted bit that equals the two accepted bits before it counts as one compand event. A loud input makes the encoder step in long runs, so the event count over a fixed page of bits follows the input level.

Each page is 1024 accepted bits. When the last bit of a page is accepted, the block turns the page's event count into a 5-bit quasi-logarithmic code. It presents that code with a single-cycle ready pulse and starts the next page from zero. The code is meant to be latched into a status register.

The stream has no back-pressure. The block accepts every strobed bit in the cycle it is presented. The result has only a valid pulse and no ready input, so the consumer must capture `pwr_code` in the pulse cycle. The code then holds its value until the next pulse.

Top module: `page_power_meter`

## Requirements
- R1: A page ends on the 1024th bit accepted since reset or since the previous page end. `pwr_valid` is high for exactly the one cycle that follows the clock edge accepting that bit, and is low at all other times.
- R2: An accepted bit whose value equals each of the two previously accepted bits adds one to the page count. Runs overlap, so four equal bits in a row give two events.
- R3: The event count and the page bit counter restart at zero for each new page. The two-bit history is kept across a page boundary, so a run that straddles the boundary counts in the new page.
- R4: The emitted code is the largest code k whose threshold T(k) does not exceed the page count. The thresholds are:
  - T(k) = k for k = 0..7
  - T(k) = 8 + 2(k-8) for k = 8..16
  - T(k) = 32 + 8(k-17) for k = 17..24
  - T(k) = 128 + 64(k-25) for k = 25..31
- R5: A page with no events yields code 0. The count saturates at 512, and any page with 512 or more events yields code 31.
- R6: `pwr_code` changes only in a cycle where `pwr_valid` is high. Between pulses it holds the last emitted code.
- R7: Cycles with `in_valid` low have no effect on the history, the event count or the page bit counter, whatever `in_bit` carries.
- R8: A synchronous active-high `rst` clears the event count, the page bit counter and the history, and forces `pwr_valid` and `pwr_code` to 0. After reset, no event can be counted until three bits have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_bit` is accepted in this cycle |
| in_bit | input | 1 | Encoder output bit |
| pwr_valid | output | 1 | One-cycle pulse: a page result is on `pwr_code` |
| pwr_code | output | 5 | Quasi-log power code of the last completed page |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the pulse is one cycle wide and follows the page end;
- the counters are zero once a pulse appears;
- the count never passes saturation;
- an idle strobe leaves the counters untouched;
- an event raises the count by exactly one;
- the code holds between pulses.

Other behaviours can only be shown by the bench's scenarios, which use pages built with known event counts:
- the mapping of a count onto the threshold table, including the neighbours of each segment edge and the saturated page;
- a run straddling a page boundary;
- gaps in the strobe carrying runs of garbage;
- a reset in mid-page that must erase the history.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int unsigned CODE_W    = 5;
  localparam int unsigned NUM_CODES = 1 << CODE_W;

  // Lower bound of the page count for a given code (piecewise-linear steps).
  function automatic int unsigned code_threshold(input int unsigned k);
    int unsigned t;
    if (k < 8)
      t = k;
    else if (k < 17)
      t = 8 + 2 * (k - 8);
    else if (k < 25)
      t = 32 + 8 * (k - 17);
    else
      t = 128 + 64 * (k - 25);
    return t;
  endfunction

endpackage

// File: rtl/pm_run_detector.sv
module pm_run_detector #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic hit
);

  localparam int unsigned HW       = RUN_LEN - 1;
  localparam int unsigned FW       = $clog2(RUN_LEN) + 1;
  localparam logic [FW-1:0] FILL_MAX = FW'(HW);

  logic [HW-1:0] hist_q;
  logic [FW-1:0] fill_q;
  logic          full;

  assign full = (fill_q == FILL_MAX);
  assign hit  = in_valid && full && (hist_q == {HW{in_bit}});

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (in_valid) begin
      hist_q <= {hist_q[HW-2:0], in_bit};
      if (!full)
        fill_q <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/pm_page_counter.sv
module pm_page_counter #(
  parameter int unsigned PAGE_BITS = 1024,
  parameter int unsigned SAT_COUNT = 512
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         hit,
  output logic                         page_end,
  output logic [$clog2(SAT_COUNT+1)-1:0] final_cnt,
  output logic [$clog2(SAT_COUNT+1)-1:0] cnt,
  output logic [$clog2(PAGE_BITS)-1:0] bit_cnt
);

  localparam int unsigned CW = $clog2(SAT_COUNT + 1);
  localparam int unsigned BW = $clog2(PAGE_BITS);
  localparam logic [CW-1:0] SAT_V  = CW'(SAT_COUNT);
  localparam logic [BW-1:0] LAST_V = BW'(PAGE_BITS - 1);

  assign page_end  = in_valid && (bit_cnt == LAST_V);
  assign final_cnt = (hit && cnt != SAT_V) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_cnt <= '0;
    end else if (in_valid) begin
      if (page_end) begin
        cnt     <= '0;
        bit_cnt <= '0;
      end else begin
        cnt     <= final_cnt;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pm_log_encoder.sv
module pm_log_encoder
  import pm_pkg::*;
#(
  parameter int unsigned CW = 10
) (
  input  logic [CW-1:0]     count,
  output logic [CODE_W-1:0] code
);

  logic [NUM_CODES-2:0] above;

  // One comparator per code step; the steps are monotone, so the code
  // equals the number of thresholds passed.
  for (genvar k = 1; k < NUM_CODES; k++) begin : g_step
    localparam logic [CW-1:0] TH = CW'(code_threshold(k));
    assign above[k-1] = (count >= TH);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_CODES - 1; i++)
      code = code + CODE_W'(above[i]);
  end

endmodule

// File: rtl/page_power_meter.sv
module page_power_meter
  import pm_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 1024,
  parameter int unsigned RUN_LEN   = 3,
  parameter int unsigned SAT_COUNT = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              pwr_valid,
  output logic [CODE_W-1:0] pwr_code
);

  localparam int unsigned CW = $clog2(SAT_COUNT + 1);
  localparam int unsigned BW = $clog2(PAGE_BITS);

  logic              hit;
  logic              page_end;
  logic [CW-1:0]     final_cnt;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bit_cnt;
  logic [CODE_W-1:0] enc_code;

  pm_run_detector #(.RUN_LEN(RUN_LEN)) u_runs (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .hit      (hit)
  );

  pm_page_counter #(.PAGE_BITS(PAGE_BITS), .SAT_COUNT(SAT_COUNT)) u_page (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .hit       (hit),
    .page_end  (page_end),
    .final_cnt (final_cnt),
    .cnt       (cnt),
    .bit_cnt   (bit_cnt)
  );

  pm_log_encoder #(.CW(CW)) u_enc (
    .count (final_cnt),
    .code  (enc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_valid <= 1'b0;
      pwr_code  <= '0;
    end else begin
      pwr_valid <= page_end;
      if (page_end)
        pwr_code <= enc_code;
    end
  end

endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int unsigned PAGE_BITS = 1024,
  parameter int unsigned SAT_COUNT = 512
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           in_valid,
  input logic                           hit,
  input logic                           page_end,
  input logic                           pwr_valid,
  input logic [4:0]                     pwr_code,
  input logic [$clog2(SAT_COUNT+1)-1:0] cnt,
  input logic [$clog2(PAGE_BITS)-1:0]   bit_cnt
);

  localparam int unsigned CW = $clog2(SAT_COUNT + 1);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pwr_valid |=> !pwr_valid);

  a_r1_pulse_follows_end: assert property (@(posedge clk) disable iff (rst)
    page_end |=> pwr_valid);

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    pwr_valid |-> (cnt == '0 && bit_cnt == '0));

  a_r2_event_adds_one: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit && !page_end && cnt < CW'(SAT_COUNT)) |=>
      (cnt == $past(cnt) + 1'b1));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(SAT_COUNT));

  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    !pwr_valid |-> $stable(pwr_code));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cnt) && $stable(bit_cnt)));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && bit_cnt == '0 && !pwr_valid && pwr_code == '0));

endmodule

bind page_power_meter pm_checker #(.PAGE_BITS(PAGE_BITS), .SAT_COUNT(SAT_COUNT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .hit       (hit),
  .page_end  (page_end),
  .pwr_valid (pwr_valid),
  .pwr_code  (pwr_code),
  .cnt       (cnt),
  .bit_cnt   (bit_cnt)
);

// File: tb/page_power_meter_test.sv
`timescale 1ns/1ps
module page_power_meter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       pwr_valid;
  logic [4:0] pwr_code;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  page_power_meter uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .pwr_valid (pwr_valid),
    .pwr_code  (pwr_code)
  );

  // Threshold list written out from R4.
  int thr [32] = '{0, 1, 2, 3, 4, 5, 6, 7,
                   8, 10, 12, 14, 16, 18, 20, 22, 24,
                   32, 40, 48, 56, 64, 72, 80, 88,
                   128, 192, 256, 320, 384, 448, 512};

  function automatic int ref_code(input int c);
    for (int k = 31; k >= 0; k--)
      if (c >= thr[k]) return k;
    return 0;
  endfunction

  // Behavioural reference model.
  int m_hist[$];
  int m_cnt = 0, m_bits = 0, m_code = 0;
  bit m_valid = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_hist.delete();
      m_cnt = 0; m_bits = 0; m_code = 0; m_valid = 1'b0;
    end else begin
      m_valid = 1'b0;
      if (in_valid) begin
        if (m_hist.size() == 2 && m_hist[0] == int'(in_bit) && m_hist[1] == int'(in_bit)
            && m_cnt < 512)
          m_cnt++;
        m_hist.push_back(int'(in_bit));
        if (m_hist.size() > 2) void'(m_hist.pop_front());
        m_bits++;
        if (m_bits == 1024) begin
          m_valid = 1'b1;
          m_code  = ref_code(m_cnt);
          m_cnt   = 0;
          m_bits  = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pwr_valid !== m_valid) begin
        fails++;
        $display("FAIL R1 pwr_valid actual %0b expected %0b at %0t", pwr_valid, m_valid, $time);
      end
      checks++;
      if (int'(pwr_code) != m_code) begin
        fails++;
        $display("FAIL R4 R6 pwr_code actual %0d expected %0d at %0t", pwr_code, m_code, $time);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input bit b);
    @(negedge clk); in_valid = 1'b1; in_bit = b;
  endtask

  task automatic idle(input int n, input bit b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b0; in_bit = b;
    end
  endtask

  // n+2 leading zeros give n events, then an alternating tail gives none.
  task automatic page_hits(input int n, input bit gaps);
    for (int i = 0; i < 1024; i++) begin
      bit b;
      b = (i < n + 2) ? 1'b0 : (((i - (n + 2)) % 2) == 0);
      send(b);
      if (gaps && (i % 7) == 0) idle(3, b);
    end
  endtask

  task automatic expect_page(input int exp, input string tag);
    @(negedge clk); in_valid = 1'b0;
    checks++;
    if (!(pwr_valid === 1'b1 && int'(pwr_code) == exp)) begin
      fails++;
      $display("FAIL %s page result actual valid=%0b code=%0d expected valid=1 code=%0d",
               tag, pwr_valid, pwr_code, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    checks++;
    if (pwr_valid !== 1'b0 || pwr_code !== 5'd0) begin
      fails++;
      $display("FAIL R8 reset state actual valid=%0b code=%0d expected 0/0", pwr_valid, pwr_code);
    end

    do_reset(); page_hits(0, 1'b0);    expect_page(0,  "R5 zero");
    do_reset(); page_hits(9, 1'b0);    expect_page(8,  "R2 R4 nine");
    do_reset(); page_hits(10, 1'b0);   expect_page(9,  "R4 ten");
    do_reset(); page_hits(31, 1'b0);   expect_page(16, "R4 thirty-one");
    do_reset(); page_hits(32, 1'b0);   expect_page(17, "R4 thirty-two");
    do_reset(); page_hits(127, 1'b0);  expect_page(24, "R4 127");
    do_reset(); page_hits(511, 1'b0);  expect_page(30, "R4 511");
    do_reset(); page_hits(512, 1'b0);  expect_page(31, "R5 512");
    do_reset(); page_hits(1022, 1'b0); expect_page(31, "R5 saturated");
    do_reset(); page_hits(10, 1'b1);   expect_page(9,  "R7 gaps");

    // R3: run straddling the page boundary counts in the second page.
    do_reset();
    for (int i = 0; i < 1024; i++) send((i < 1022) ? bit'(i % 2) : 1'b0);
    expect_page(0, "R3 first page");
    for (int i = 0; i < 1024; i++) send((i == 0) ? 1'b0 : bit'(i % 2));
    expect_page(1, "R3 boundary run");

    // R8: mid-page reset erases history and count.
    do_reset();
    for (int i = 0; i < 500; i++) send(1'b0);
    do_reset();
    for (int i = 0; i < 1024; i++) send(bit'(i % 2));
    expect_page(0, "R8 mid-page reset");

    idle(4, 1'b1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule